// File: doc/BRIEF.md
# Clock Period Glitch Monitor

This block watches a slower, asynchronous clock with a faster sampling clock. It brings the watched clock into the sampling domain, finds its active edges and counts the sampling cycles between consecutive edges. Each count is one period measurement, and every measurement is checked against programmable lower and upper bounds. A period below the lower bound means an extra pulse arrived, such as a double edge or a short runt cycle. A stretch without an edge that runs past the upper bound means a pulse went missing. The two fault classes are held in separate sticky flags.

Good periods are grouped into blocks of `2**AVG_LOG` periods, and the mean of each block is compared against a programmable target window. The monitor reports that the clock is qualified only after `GOOD_N` block means in a row have landed inside the window with no fault in between. A settle timer starts at reset and again at each re-arm. If qualification has not been reached within `SETTLE_CYC` sampling cycles, a timeout output is raised.

Typical use: firmware applies a new clock profile, pulses re-arm, and waits for either qualified or timeout. It then reads the two sticky flags to learn whether any runt or dropped cycle occurred.

Top module: `clkper_guard`

## Requirements
- R1: While reset is asserted and immediately after reset, all five outputs (extra_flag, miss_flag, in_win, qualified, timeout) are 0.
- R2: A measured period, in sampling cycles between consecutive active edges, that is strictly less than `min_per` sets `extra_flag`.
- R3: When more than `max_per` sampling cycles pass after an active edge with no further edge, `miss_flag` is set. It is set without waiting for the late edge to arrive.
- R4: The bounds are inclusive. A period exactly equal to `min_per` or to `max_per` raises no flag.
- R5: The mean of each block of `2**AVG_LOG` consecutive fault-free periods is compared against the window. `in_win` becomes 1 when `win_lo <= mean <= win_hi` and 0 otherwise. `in_win` keeps its value until the next block completes.
- R6: `qualified` is 1 once `GOOD_N` consecutive block means have been inside the window. Any faulty period (short or long) or any out-of-window mean clears this progress. A faulty period also discards the partly filled block.
- R7: `extra_flag` and `miss_flag` stay set until a one-cycle pulse on `clr_flags` clears both of them. If a new fault occurs in the same cycle as the clear, the flag is set.
- R8: If `qualified` has not been reached within `SETTLE_CYC` sampling cycles of reset or re-arm, `timeout` is set and holds until the next re-arm. Once qualification is reached, the timer stops.
- R9: A `rearm` pulse discards the reference edge and all averaging and qualification progress. On the next cycle it clears `in_win`, `qualified` and `timeout` and restarts the settle timer. It leaves `extra_flag` and `miss_flag` unchanged.
- R10: `min_per`, `max_per`, `win_lo` and `win_hi` may be changed while the monitor runs. New values apply to the measurements that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Watched clock, asynchronous to clk |
| rearm | input | 1 | One-cycle pulse that restarts qualification and the settle timer |
| clr_flags | input | 1 | One-cycle pulse that clears both sticky fault flags |
| min_per | input | CNT_W | Shortest acceptable period, in sampling cycles |
| max_per | input | CNT_W | Longest acceptable period, in sampling cycles |
| win_lo | input | CNT_W | Lower edge of the target window for the block mean |
| win_hi | input | CNT_W | Upper edge of the target window for the block mean |
| extra_flag | output | 1 | Sticky: a period shorter than min_per was seen |
| miss_flag | output | 1 | Sticky: a period longer than max_per was seen |
| in_win | output | 1 | Latest block mean lies inside the target window |
| qualified | output | 1 | GOOD_N consecutive block means were in the window |
| timeout | output | 1 | Qualification was not reached within SETTLE_CYC cycles |

## Verification
The watched clock runs from a free-running generator, so period changes take effect at clean period boundaries and the checks never disturb its timing. It is driven with a steady in-window period, with a single injected runt cycle, with a silent stretch, and with periods placed exactly on each bound and one cycle outside it. These cases separate an inclusive bound compare from an exclusive one, and they show that an extra pulse and a missing pulse land in different flags. A steady period that sits inside the fault bounds but outside the target window shows that the window decision is made apart from the fault checks. Moving the window live over that same period then shows that the registers apply at runtime. A never-qualifying run after re-arm checks that the timeout is raised and cleared, and that the sticky flags survive the re-arm.

// File: rtl/clkper_pkg.sv
package clkper_pkg;

   // Classification of one completed period measurement
   typedef enum logic [1:0] {
      PER_OK    = 2'd0,
      PER_SHORT = 2'd1,
      PER_LONG  = 2'd2
   } per_cls_e;

endpackage

// File: rtl/clkper_sync.sv
module clkper_sync #(
   parameter int STAGES    = 2,
   parameter bit RISE_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_p
);

   if (STAGES < 2) begin : g_bad_stages
      $error("clkper_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         last  <= chain[STAGES-1];
      end
   end

   if (RISE_EDGE) begin : g_rise
      assign edge_p = chain[STAGES-1] & ~last;
   end else begin : g_fall
      assign edge_p = ~chain[STAGES-1] & last;
   end

endmodule

// File: rtl/clkper_period.sv
module clkper_period
   import clkper_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rearm,
   input  logic             edge_p,
   input  logic [CNT_W-1:0] min_per,
   input  logic [CNT_W-1:0] max_per,
   output logic             meas_vld,
   output logic [CNT_W-1:0] meas_per,
   output per_cls_e         meas_cls,
   output logic             gap_hit
);

   logic [CNT_W-1:0] cnt;
   logic             have_ref;
   logic             gap_seen;

   assign meas_per = cnt;
   assign meas_vld = edge_p && have_ref && !gap_seen;
   assign gap_hit  = have_ref && !gap_seen && !edge_p && (cnt > max_per);

   always_comb begin
      if (cnt < min_per)      meas_cls = PER_SHORT;
      else if (cnt > max_per) meas_cls = PER_LONG;
      else                    meas_cls = PER_OK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         have_ref <= 1'b0;
         gap_seen <= 1'b0;
      end else if (rearm) begin
         cnt      <= '0;
         have_ref <= 1'b0;
         gap_seen <= 1'b0;
      end else if (edge_p) begin
         cnt      <= CNT_W'(1);
         have_ref <= 1'b1;
         gap_seen <= 1'b0;
      end else begin
         if (cnt != '1) cnt <= cnt + 1'b1;
         if (gap_hit)   gap_seen <= 1'b1;
      end
   end

   // a silent stretch is reported once, not every cycle (R3)
   p_gap_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gap_hit |=> !gap_hit);

endmodule

// File: rtl/clkper_qual.sv
module clkper_qual
   import clkper_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int AVG_LOG = 2,
   parameter int GOOD_N  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rearm,
   input  logic             meas_vld,
   input  logic [CNT_W-1:0] meas_per,
   input  per_cls_e         meas_cls,
   input  logic             gap_hit,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   output logic             in_win,
   output logic             qualified
);

   localparam int GW    = $clog2(GOOD_N + 1);
   localparam int SUM_W = CNT_W + AVG_LOG;

   if (GOOD_N < 1) begin : g_bad_good
      $error("clkper_qual: GOOD_N must be at least 1");
   end
   if (AVG_LOG < 0 || AVG_LOG > 8) begin : g_bad_avg
      $error("clkper_qual: AVG_LOG out of range");
   end

   logic             bad;
   logic             restart;
   logic             good_meas;
   logic             blk_done;
   logic [CNT_W-1:0] avg;
   logic             avg_ok;
   logic [GW-1:0]    good_cnt;

   assign bad       = gap_hit || (meas_vld && meas_cls != PER_OK);
   assign restart   = rearm || bad;
   assign good_meas = meas_vld && meas_cls == PER_OK;
   assign avg_ok    = (avg >= win_lo) && (avg <= win_hi);

   if (AVG_LOG == 0) begin : g_single
      assign blk_done = 1'b1;
      assign avg      = meas_per;
   end else begin : g_block
      logic [AVG_LOG-1:0] nacc;
      logic [SUM_W-1:0]   acc;
      logic [SUM_W-1:0]   sum_now;

      assign sum_now  = acc + SUM_W'(meas_per);
      assign blk_done = &nacc;
      assign avg      = sum_now[AVG_LOG +: CNT_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nacc <= '0;
            acc  <= '0;
         end else if (restart) begin
            nacc <= '0;
            acc  <= '0;
         end else if (good_meas) begin
            if (blk_done) begin
               nacc <= '0;
               acc  <= '0;
            end else begin
               nacc <= nacc + 1'b1;
               acc  <= sum_now;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt <= '0;
         in_win   <= 1'b0;
      end else if (rearm) begin
         good_cnt <= '0;
         in_win   <= 1'b0;
      end else if (bad) begin
         good_cnt <= '0;
      end else if (good_meas && blk_done) begin
         in_win <= avg_ok;
         if (!avg_ok)                      good_cnt <= '0;
         else if (good_cnt != GW'(GOOD_N)) good_cnt <= good_cnt + 1'b1;
      end
   end

   assign qualified = (good_cnt == GW'(GOOD_N));

   // qualification implies the latest block mean sat in the window (R6)
   p_qual_in_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
      qualified |-> in_win);

   // a faulty period drops qualification on the next cycle (R6)
   p_bad_drops_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !rearm) |=> !qualified);

endmodule

// File: rtl/clkper_guard.sv
module clkper_guard
   import clkper_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit RISE_EDGE   = 1'b1,
   parameter int AVG_LOG     = 2,
   parameter int GOOD_N      = 8,
   parameter int SETTLE_CYC  = 100000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mon_clk,
   input  logic             rearm,
   input  logic             clr_flags,
   input  logic [CNT_W-1:0] min_per,
   input  logic [CNT_W-1:0] max_per,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   output logic             extra_flag,
   output logic             miss_flag,
   output logic             in_win,
   output logic             qualified,
   output logic             timeout
);

   localparam int TMR_W = $clog2(SETTLE_CYC + 1);

   if (SETTLE_CYC < 2) begin : g_bad_settle
      $error("clkper_guard: SETTLE_CYC must be at least 2");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("clkper_guard: CNT_W too small");
   end

   logic             edge_p;
   logic             meas_vld;
   logic [CNT_W-1:0] meas_per;
   per_cls_e         meas_cls;
   logic             gap_hit;
   logic             set_extra;
   logic             set_miss;
   logic [TMR_W-1:0] tmr;
   logic             settled;

   clkper_sync #(.STAGES(SYNC_STAGES), .RISE_EDGE(RISE_EDGE)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(mon_clk), .edge_p(edge_p));

   clkper_period #(.CNT_W(CNT_W)) u_period (
      .clk(clk), .rst_n(rst_n), .rearm(rearm), .edge_p(edge_p),
      .min_per(min_per), .max_per(max_per),
      .meas_vld(meas_vld), .meas_per(meas_per), .meas_cls(meas_cls),
      .gap_hit(gap_hit));

   clkper_qual #(.CNT_W(CNT_W), .AVG_LOG(AVG_LOG), .GOOD_N(GOOD_N)) u_qual (
      .clk(clk), .rst_n(rst_n), .rearm(rearm),
      .meas_vld(meas_vld), .meas_per(meas_per), .meas_cls(meas_cls),
      .gap_hit(gap_hit), .win_lo(win_lo), .win_hi(win_hi),
      .in_win(in_win), .qualified(qualified));

   assign set_extra = meas_vld && meas_cls == PER_SHORT;
   assign set_miss  = gap_hit || (meas_vld && meas_cls == PER_LONG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         extra_flag <= 1'b0;
         miss_flag  <= 1'b0;
      end else begin
         extra_flag <= set_extra || (extra_flag && !clr_flags);
         miss_flag  <= set_miss  || (miss_flag  && !clr_flags);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr     <= '0;
         settled <= 1'b0;
         timeout <= 1'b0;
      end else if (rearm) begin
         tmr     <= '0;
         settled <= 1'b0;
         timeout <= 1'b0;
      end else if (!settled) begin
         if (qualified) begin
            settled <= 1'b1;
         end else if (tmr == TMR_W'(SETTLE_CYC - 1)) begin
            timeout <= 1'b1;
            settled <= 1'b1;
         end else begin
            tmr <= tmr + 1'b1;
         end
      end
   end

   p_short_sets_extra_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && meas_cls == PER_SHORT) |=> extra_flag);

   p_gap_sets_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gap_hit |=> miss_flag);

   p_extra_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (extra_flag && !clr_flags) |=> extra_flag);

   p_miss_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_flag && !clr_flags) |=> miss_flag);

   p_timeout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !rearm) |=> timeout);

   p_rearm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> (!timeout && !qualified && !in_win));

endmodule

// File: tb/clkper_guard_tb_top.sv
module clkper_guard_tb_top;

   localparam int CNT_W  = 12;
   localparam int SETTLE = 1500;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             mon_clk = 1'b0;
   logic             rearm = 1'b0;
   logic             clr_flags = 1'b0;
   logic [CNT_W-1:0] min_per = 12'd8;
   logic [CNT_W-1:0] max_per = 12'd24;
   logic [CNT_W-1:0] win_lo  = 12'd14;
   logic [CNT_W-1:0] win_hi  = 12'd18;
   logic             extra_flag, miss_flag, in_win, qualified, timeout;

   int  mon_per = 16;
   bit  mon_en = 1'b0;
   bit  glitch_req = 1'b0;
   int  n_vec = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   typedef struct {
      string      tag;
      logic [4:0] exp;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   clkper_guard #(
      .CNT_W(CNT_W), .SYNC_STAGES(2), .RISE_EDGE(1'b1),
      .AVG_LOG(2), .GOOD_N(4), .SETTLE_CYC(SETTLE)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .rearm(rearm),
      .clr_flags(clr_flags), .min_per(min_per), .max_per(max_per),
      .win_lo(win_lo), .win_hi(win_hi), .extra_flag(extra_flag),
      .miss_flag(miss_flag), .in_win(in_win), .qualified(qualified),
      .timeout(timeout));

   // free-running watched clock: each period starts with a rising edge
   initial begin
      forever begin
         int p;
         if (mon_en) begin
            p = glitch_req ? 4 : mon_per;
            glitch_req = 1'b0;
            mon_clk = 1'b1;
            repeat (p / 2) @(negedge clk);
            mon_clk = 1'b0;
            repeat (p - p / 2) @(negedge clk);
         end else begin
            mon_clk = 1'b0;
            @(negedge clk);
         end
      end
   end

   // monitor: pops expected items and compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [4:0] got;
            it  = sb_q.pop_front();
            got = {extra_flag, miss_flag, in_win, qualified, timeout};
            n_vec++;
            if (got !== it.exp) begin
               n_bad++;
               $display("FAIL %s: {extra,miss,in_win,qual,tmo} got %b expected %b",
                        it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic expect_out(input string tag, input logic [4:0] exp);
      item_t it;
      it.tag = tag;
      it.exp = exp;
      sb_q.push_back(it);
      @(negedge clk);
      #1;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_flags = 1'b1;
      @(negedge clk); clr_flags = 1'b0;
   endtask

   task automatic pulse_rearm();
      @(negedge clk); rearm = 1'b1;
      @(negedge clk); rearm = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      expect_out("R1 outputs low in reset", 5'b00000);
      rst_n = 1'b1;
      wait_cyc(2);
      expect_out("R1 outputs low after reset", 5'b00000);

      // steady in-window clock
      mon_en = 1'b1;
      wait_cyc(22 * 16);
      expect_out("R5 R6 steady 16 qualifies", 5'b00110);

      // one runt cycle
      glitch_req = 1'b1;
      wait_cyc(3 * 16);
      expect_out("R2 R6 runt sets extra, drops qual", 5'b10100);
      wait_cyc(22 * 16);
      expect_out("R7 extra sticky after requalify", 5'b10110);
      pulse_clr();
      expect_out("R7 clear strobe clears extra", 5'b00110);

      // silent stretch
      mon_en = 1'b0;
      wait_cyc(70);
      expect_out("R3 gap sets miss, drops qual", 5'b01100);
      mon_en = 1'b1;
      wait_cyc(22 * 16);
      expect_out("R7 miss sticky after requalify", 5'b01110);
      pulse_clr();
      expect_out("R7 clear strobe clears miss", 5'b00110);

      // inside fault bounds, outside target window
      mon_per = 20;
      wait_cyc(22 * 20);
      expect_out("R5 period 20 outside window 14..18", 5'b00000);
      win_lo = 12'd19;
      win_hi = 12'd21;
      wait_cyc(22 * 20);
      expect_out("R10 live window 19..21 qualifies", 5'b00110);

      // bounds exactly hit
      mon_per = 8;  win_lo = 12'd7;  win_hi = 12'd9;
      wait_cyc(25 * 8 + 20);
      expect_out("R4 period equal to min_per is clean", 5'b00110);
      mon_per = 24; win_lo = 12'd23; win_hi = 12'd25;
      wait_cyc(22 * 24);
      expect_out("R4 period equal to max_per is clean", 5'b00110);

      // one past the bounds
      mon_per = 25; win_lo = 12'd20; win_hi = 12'd30;
      wait_cyc(10 * 25);
      expect_out("R3 period max_per+1 sets miss", 5'b01100);
      mon_per = 7;
      wait_cyc(3 * 25);
      pulse_clr();
      wait_cyc(10 * 7);
      expect_out("R2 period min_per-1 sets extra", 5'b10100);

      // settle timeout after re-arm
      mon_per = 20; win_lo = 12'd14; win_hi = 12'd18;
      wait_cyc(3 * 20);
      pulse_clr();
      wait_cyc(2 * 20);
      expect_out("R2 extra reset by clear before rearm", 5'b00000);
      glitch_req = 1'b1;
      wait_cyc(3 * 20);
      expect_out("R2 runt at period 20 sets extra", 5'b10000);
      pulse_rearm();
      expect_out("R9 rearm keeps flags, clears rest", 5'b10000);
      wait_cyc(SETTLE + 100);
      expect_out("R8 timeout after settle window", 5'b10001);
      wait_cyc(200);
      expect_out("R8 timeout holds", 5'b10001);
      pulse_rearm();
      expect_out("R9 rearm clears timeout", 5'b10000);

      wait_cyc(2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule